// File: doc/BRIEF.md
# Dual-Issue Class Pairing Controller

This block is the in-order issue stage of a limited dual-issue pipeline. Each cycle the fetch side presents an aligned pair of instructions. Every instruction carries a one-bit class tag, written when the line was filled into the instruction cache. The tag marks the instruction either as a floating-point arithmetic operation or as something else. The controller reads only that tag. It steers each instruction to one of two lanes, an FP lane and a general lane, and it never sends more than one instruction to a lane in a cycle.

Issue is strictly in program order. Slot 0 of a pair goes before slot 1. A pair whose two instructions differ in class can go out together, whichever slot holds the FP one. A pair of two instructions of the same class takes two cycles. When a branch lands on the odd half of a pair, the fetch side raises an odd-entry flag and the even slot is ignored. When the lane that the oldest waiting instruction needs reports busy, the pipeline slips and nothing younger is issued around it. The controller asks for the next pair only when the current one is fully issued. A flush from branch resolution drops a half-issued pair at once.

Top module: `dual_issue_pairer`

## Requirements
- R1: While reset is high, and on the first cycle after it, both lane valid outputs are 0. With no pair offered, `fetch_adv` is 0.
- R2: A pair whose slots differ in class tag (tag 1 = FP, tag 0 = general) issues both slots in the same cycle, with either slot order. `fetch_adv` is 1 in that cycle.
- R3: A pair whose two slots have the same class issues slot 0 in the first cycle and slot 1 in a later cycle. `fetch_adv` is 0 in the first cycle and 1 only in the cycle slot 1 issues.
- R4: With `odd_entry` = 1, slot 0 is never issued, and slot 1 issues alone in its lane with `fetch_adv` = 1.
- R5: If the lane for the oldest pending slot is busy, nothing issues that cycle, even when the other slot's lane is free, and `fetch_adv` stays 0.
- R6: If slot 0 has issued and slot 1's lane is busy, slot 1 waits with `fetch_adv` at 0. It issues in the first cycle its lane is free.
- R7: A cycle with `flush` = 1 issues nothing and drives `fetch_adv` to 0. It clears any pending second slot, so the next offered pair starts again at slot 0.
- R8: Each lane receives at most one instruction per cycle. A lane output carries the instruction and the slot index (0 or 1) it came from.
- R9: A lane's outputs show an issue decision one clock after the cycle in which it was made. `fetch_adv` is combinational in that same decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard current pair and pending state |
| pair_valid | input | 1 | A fetched pair is offered |
| odd_entry | input | 1 | Branch target at slot 1; slot 0 invalid |
| slot0_ins | input | INSTR_W | Even-slot instruction |
| slot0_cls | input | 1 | Even-slot class tag (1 = FP) |
| slot1_ins | input | INSTR_W | Odd-slot instruction |
| slot1_cls | input | 1 | Odd-slot class tag (1 = FP) |
| fp_busy | input | 1 | FP lane long-latency resource busy |
| gen_busy | input | 1 | General lane long-latency resource busy |
| fetch_adv | output | 1 | Pair consumed; present next pair |
| fp_vld | output | 1 | FP lane issue valid (registered) |
| fp_slot | output | 1 | Source slot of FP lane instruction |
| fp_ins | output | INSTR_W | FP lane instruction |
| gen_vld | output | 1 | General lane issue valid (registered) |
| gen_slot | output | 1 | Source slot of general lane instruction |
| gen_ins | output | INSTR_W | General lane instruction |

## Verification
The only state inside the block is the "slot 0 already issued" flag. Suppose it is set when it should not be. Then the next same-class pair skips its even slot, and the lanes show slot 1 one cycle later. If it stays clear when it should be set, slot 0 is issued twice and `fetch_adv` comes late. Either error is visible at the lane outputs within a cycle of the pair that follows. Steering mistakes show up in the very next cycle as a wrong slot index, a wrong instruction word, or a lane that issues during a slip.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_W    = $clog2(NUM_LANES);
  typedef enum logic {CLS_GEN = 1'b0, CLS_FP = 1'b1} iclass_e;
endpackage

// File: rtl/dip_sequencer.sv
module dip_sequencer
  import dip_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic pair_valid,
  input  logic odd_entry,
  input  logic cls0,
  input  logic cls1,
  input  logic fp_busy,
  input  logic gen_busy,
  output logic iss0,
  output logic iss1,
  output logic fetch_adv
);
  logic done0;
  logic s0_pend;
  logic busy0, busy1;

  assign s0_pend = pair_valid && !odd_entry && !done0;
  assign busy0   = (cls0 == CLS_FP) ? fp_busy : gen_busy;
  assign busy1   = (cls1 == CLS_FP) ? fp_busy : gen_busy;

  // slot 0 first; slot 1 only once slot 0 is out or going out in another lane
  always_comb begin
    iss0 = !flush && s0_pend && !busy0;
    iss1 = !flush && pair_valid && !busy1 &&
           (!s0_pend || (iss0 && (cls0 != cls1)));
  end

  assign fetch_adv = iss1;

  always_ff @(posedge clk) begin
    if (rst || flush)  done0 <= 1'b0;
    else if (iss1)     done0 <= 1'b0;
    else if (iss0)     done0 <= 1'b1;
  end

  AST_SLIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (s0_pend && busy0) |-> (!iss0 && !iss1 && !fetch_adv)); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !done0); // R7
  AST_ADV_ENDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    fetch_adv |=> !done0); // R3
  AST_ODD_SKIPS_S0: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && odd_entry && !done0) |-> !iss0); // R4
endmodule

// File: rtl/dip_router.sv
module dip_router
  import dip_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               iss0,
  input  logic               iss1,
  input  logic               cls0,
  input  logic               cls1,
  input  logic [INSTR_W-1:0] ins0,
  input  logic [INSTR_W-1:0] ins1,
  output logic [NUM_LANES-1:0]              req,
  output logic [NUM_LANES-1:0]              slot,
  output logic [NUM_LANES-1:0][INSTR_W-1:0] ins
);
  // lane index equals class tag value: 0 general, 1 FP
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic hit0, hit1;
    assign hit0    = iss0 && (cls0 == l[0]);
    assign hit1    = iss1 && (cls1 == l[0]);
    assign req[l]  = hit0 || hit1;
    assign slot[l] = !hit0;
    assign ins[l]  = hit0 ? ins0 : ins1;
  end
endmodule

// File: rtl/dip_lane_reg.sv
module dip_lane_reg #(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               slot_in,
  input  logic [INSTR_W-1:0] ins_in,
  output logic               vld,
  output logic               slot,
  output logic [INSTR_W-1:0] ins
);
  always_ff @(posedge clk) begin
    if (rst) vld <= 1'b0;
    else     vld <= req;
    if (req) begin
      slot <= slot_in;
      ins  <= ins_in;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !vld); // R1
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req |=> (vld && ins == $past(ins_in))); // R9
endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dip_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               pair_valid,
  input  logic               odd_entry,
  input  logic [INSTR_W-1:0] slot0_ins,
  input  logic               slot0_cls,
  input  logic [INSTR_W-1:0] slot1_ins,
  input  logic               slot1_cls,
  input  logic               fp_busy,
  input  logic               gen_busy,
  output logic               fetch_adv,
  output logic               fp_vld,
  output logic               fp_slot,
  output logic [INSTR_W-1:0] fp_ins,
  output logic               gen_vld,
  output logic               gen_slot,
  output logic [INSTR_W-1:0] gen_ins
);
  logic iss0, iss1;
  logic [NUM_LANES-1:0]              l_req, l_slot_in, l_vld, l_slot;
  logic [NUM_LANES-1:0][INSTR_W-1:0] l_ins_in, l_ins;

  dip_sequencer u_seq (
    .clk(clk), .rst(rst), .flush(flush), .pair_valid(pair_valid),
    .odd_entry(odd_entry), .cls0(slot0_cls), .cls1(slot1_cls),
    .fp_busy(fp_busy), .gen_busy(gen_busy),
    .iss0(iss0), .iss1(iss1), .fetch_adv(fetch_adv)
  );

  dip_router #(.INSTR_W(INSTR_W)) u_rt (
    .iss0(iss0), .iss1(iss1), .cls0(slot0_cls), .cls1(slot1_cls),
    .ins0(slot0_ins), .ins1(slot1_ins),
    .req(l_req), .slot(l_slot_in), .ins(l_ins_in)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_reg
    dip_lane_reg #(.INSTR_W(INSTR_W)) u_lane (
      .clk(clk), .rst(rst), .req(l_req[l]), .slot_in(l_slot_in[l]),
      .ins_in(l_ins_in[l]), .vld(l_vld[l]), .slot(l_slot[l]), .ins(l_ins[l])
    );
  end

  assign gen_vld  = l_vld[0];
  assign gen_slot = l_slot[0];
  assign gen_ins  = l_ins[0];
  assign fp_vld   = l_vld[1];
  assign fp_slot  = l_slot[1];
  assign fp_ins   = l_ins[1];

  AST_LANES_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    (fp_vld && gen_vld) |-> (fp_slot != gen_slot)); // R8
  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!fp_vld && !gen_vld)); // R7
  AST_ODD_NO_EVEN: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && odd_entry && !flush) |=>
      !((fp_vld && !fp_slot) || (gen_vld && !gen_slot))); // R4
  AST_MIXED_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !odd_entry && !flush && !fp_busy && !gen_busy &&
     (slot0_cls != slot1_cls)) |-> fetch_adv); // R2
endmodule

// File: tb/dual_issue_pairer_bench.sv
module dual_issue_pairer_bench;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst, flush, pair_valid, odd_entry, slot0_cls, slot1_cls, fp_busy, gen_busy;
  logic [W-1:0] slot0_ins, slot1_ins;
  logic fetch_adv, fp_vld, fp_slot, gen_vld, gen_slot;
  logic [W-1:0] fp_ins, gen_ins;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dual_issue_pairer #(.INSTR_W(W)) u_dual_issue_pairer (
    .clk(clk), .rst(rst), .flush(flush), .pair_valid(pair_valid),
    .odd_entry(odd_entry), .slot0_ins(slot0_ins), .slot0_cls(slot0_cls),
    .slot1_ins(slot1_ins), .slot1_cls(slot1_cls), .fp_busy(fp_busy),
    .gen_busy(gen_busy), .fetch_adv(fetch_adv), .fp_vld(fp_vld),
    .fp_slot(fp_slot), .fp_ins(fp_ins), .gen_vld(gen_vld),
    .gen_slot(gen_slot), .gen_ins(gen_ins)
  );

  // {odd, c0, c1, fpb, genb, exp_fpv, exp_fps, exp_genv, exp_gens, exp_adv}
  localparam logic [9:0] VEC [12] = '{
    10'b0_1_0_0_0_1_0_1_1_1, // R2 fp slot0, gen slot1
    10'b0_0_1_0_0_1_1_1_0_1, // R2 reversed
    10'b0_1_1_0_0_1_0_0_0_0, // R3 R8 fp pair: slot0 only
    10'b0_0_0_0_0_0_0_1_0_0, // R3 gen pair: slot0 only
    10'b1_1_0_0_0_0_0_1_1_1, // R4 odd, gen slot1
    10'b1_0_1_0_0_1_1_0_0_1, // R4 odd, fp slot1
    10'b0_1_0_1_0_0_0_0_0_0, // R5 fp busy blocks slot0 and slot1
    10'b0_0_1_1_0_0_0_1_0_0, // R6 slot1 fp waits
    10'b0_0_1_0_1_0_0_0_0_0, // R5 gen busy blocks all
    10'b1_0_1_1_0_0_0_0_0_0, // R5 odd slot1 blocked
    10'b0_1_0_0_1_1_0_0_0_0, // R6 slot1 gen waits
    10'b0_1_1_1_1_0_0_0_0_0  // R5 all busy
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lanes(input string req, input logic efv, input logic efs,
                       input logic egv, input logic egs, input int k);
    chk(req, {63'd0, fp_vld}, {63'd0, efv});
    chk(req, {63'd0, gen_vld}, {63'd0, egv});
    if (efv) begin
      chk(req, {63'd0, fp_slot}, {63'd0, efs});
      chk(req, {32'd0, fp_ins}, {32'd0, (efs ? 32'hB000_0000 : 32'hA000_0000) | k});
    end
    if (egv) begin
      chk(req, {63'd0, gen_slot}, {63'd0, egs});
      chk(req, {32'd0, gen_ins}, {32'd0, (egs ? 32'hB000_0000 : 32'hA000_0000) | k});
    end
  endtask

  task automatic offer(input logic odd, input logic c0, input logic c1,
                       input logic fb, input logic gb, input int k);
    pair_valid = 1'b1; odd_entry = odd; slot0_cls = c0; slot1_cls = c1;
    fp_busy = fb; gen_busy = gb; flush = 1'b0;
    slot0_ins = 32'hA000_0000 | k; slot1_ins = 32'hB000_0000 | k;
  endtask

  task automatic idle_flush();
    pair_valid = 1'b0; flush = 1'b1; fp_busy = 1'b0; gen_busy = 1'b0;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; flush = 1'b0; pair_valid = 1'b0; odd_entry = 1'b0;
    slot0_cls = 1'b0; slot1_cls = 1'b0; fp_busy = 1'b0; gen_busy = 1'b0;
    slot0_ins = '0; slot1_ins = '0;
    repeat (3) @(negedge clk);
    chk("R1 fp_vld", {63'd0, fp_vld}, 64'd0);
    chk("R1 gen_vld", {63'd0, gen_vld}, 64'd0);
    chk("R1 fetch_adv", {63'd0, fetch_adv}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {62'd0, fp_vld, gen_vld}, 64'd0);

    // vector table: each entry from a clean state, then flush
    for (int k = 0; k < 12; k++) begin
      logic [9:0] v;
      v = VEC[k];
      offer(v[9], v[8], v[7], v[6], v[5], k);
      #1 chk("R2-table adv", {63'd0, fetch_adv}, {63'd0, v[0]});
      @(negedge clk);
      idle_flush();
      lanes("R9 table lanes", v[4], v[3], v[2], v[1], k);
      @(negedge clk);
      flush = 1'b0;
    end

    // R3: same-class pair over two cycles
    offer(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 40);
    #1 chk("R3 adv first", {63'd0, fetch_adv}, 64'd0);
    @(negedge clk);
    lanes("R3 first issue", 1'b1, 1'b0, 1'b0, 1'b0, 40);
    #1 chk("R3 adv second", {63'd0, fetch_adv}, 64'd1);
    @(negedge clk);
    pair_valid = 1'b0;
    lanes("R3 second issue", 1'b1, 1'b1, 1'b0, 1'b0, 40);
    @(negedge clk);

    // R7: flush during pending second slot restarts at slot 0
    offer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 50);
    @(negedge clk);
    flush = 1'b1;
    #1 chk("R7 adv on flush", {63'd0, fetch_adv}, 64'd0);
    @(negedge clk);
    flush = 1'b0;
    lanes("R7 nothing on flush", 1'b0, 1'b0, 1'b0, 1'b0, 50);
    #1 chk("R7 restart adv", {63'd0, fetch_adv}, 64'd0);
    @(negedge clk);
    idle_flush();
    lanes("R7 restart slot0", 1'b0, 1'b0, 1'b1, 1'b0, 50);
    @(negedge clk);
    flush = 1'b0;

    // R6: slot1 waits for its lane then issues
    offer(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 60);
    #1 chk("R6 adv busy", {63'd0, fetch_adv}, 64'd0);
    @(negedge clk);
    lanes("R6 slot0 out", 1'b0, 1'b0, 1'b1, 1'b0, 60);
    #1 chk("R6 adv still busy", {63'd0, fetch_adv}, 64'd0);
    @(negedge clk);
    lanes("R6 slip", 1'b0, 1'b0, 1'b0, 1'b0, 60);
    fp_busy = 1'b0;
    #1 chk("R6 adv freed", {63'd0, fetch_adv}, 64'd1);
    @(negedge clk);
    pair_valid = 1'b0;
    lanes("R6 slot1 out", 1'b1, 1'b1, 1'b0, 1'b0, 60);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule